// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This unit sits beside a scatter-gather DMA channel and turns its stream of per-descriptor completion pulses into fewer interrupts. A programmable threshold sets how many completions are collected before the completion flag is raised. A delay timer covers the case where traffic stops before the threshold is reached. The timer is armed when a packet ends. It counts in ticks of 125 clocks and raises a delay flag once the programmed number of ticks has passed with no new packet starting.

Software-side logic writes a 32-bit control word. That word holds a run bit, one interrupt enable for each flag, the threshold and the delay. The completion, delay and error flags are sticky and are cleared through a write-1-to-clear acknowledge port. One level interrupt line is high while any enabled flag is set.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the control readback is 0x0001_0002 (threshold 1, delay 0, bit 1 set), all three status flags are 0 and `irq` is 0.
- R2: A control write stores run (bit 0), completion enable (bit 12), delay enable (bit 13), error enable (bit 14), threshold (bits 23:16) and delay (bits 31:24). The stored values appear on the readback in the cycle after the write. The other bits read 0, except bit 1, which always reads 1.
- R3: A control write whose threshold field is 0 leaves the stored threshold unchanged, and the other fields are still written.
- R4: With run set, the completion flag rises in the cycle after the threshold-th completion pulse. The countdown then reloads from the threshold. A write with a nonzero threshold also reloads the countdown.
- R5: With run set and delay N nonzero, an end-of-packet pulse arms the timer, and the delay flag rises exactly 125×N clocks after the edge that sampled that pulse. That timeout also reloads the completion countdown.
- R6: A start-of-packet pulse (not paired with an end-of-packet pulse in the same cycle) disarms the timer, so no timeout follows until the next end of packet.
- R7: A delay of 0 disables the timeout, and the timer stays disarmed.
- R8: While run is 0, completion pulses and packet pulses are ignored. The countdown holds and the timer stays disarmed.
- R9: An error pulse sets the error flag in the next cycle, whatever the state of run.
- R10: Flags are sticky. `ack_data` bit 0 clears the completion flag, bit 1 the delay flag and bit 2 the error flag when `ack_we` is high. A set in the same cycle wins over a clear.
- R11: `irq` is high exactly when some flag is set and its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback |
| evt_done | input | 1 | Descriptor completion pulse |
| evt_eop | input | 1 | End-of-packet pulse |
| evt_sop | input | 1 | Start-of-packet pulse |
| evt_err | input | 1 | Error pulse |
| ack_we | input | 1 | Acknowledge strobe |
| ack_data | input | 3 | Write-1-to-clear mask {error, delay, completion} |
| sts_done | output | 1 | Sticky completion flag |
| sts_dly | output | 1 | Sticky delay-timeout flag |
| sts_err | output | 1 | Sticky error flag |
| irq | output | 1 | Level interrupt |

## Verification
The countdown is driven with runs of completions shorter than, equal to and longer than the threshold. This separates an off-by-one in the count from a missing reload. The delay timer is armed and then observed one clock before and exactly at the 125×N boundary. It is also disarmed early by a start of packet, and it is run with a zero delay. Together these separate tick miscounts, failed restarts and a broken disable. The same pulses are repeated with run cleared, and error pulses coincide with acknowledges. These cases tell a gating or priority fault apart from a plain flag fault.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // control word layout (fixed positions)
  localparam int CTRL_W      = 32;
  localparam int RUN_BIT     = 0;
  localparam int ONE_BIT     = 1;
  localparam int DONE_EN_BIT = 12;
  localparam int DLY_EN_BIT  = 13;
  localparam int ERR_EN_BIT  = 14;
  localparam int THR_LSB     = 16;
  localparam int THR_MSB     = 23;
  localparam int DLY_LSB     = 24;
  localparam int DLY_MSB     = 31;
  localparam int THR_W       = THR_MSB - THR_LSB + 1;
  localparam int DLY_W       = DLY_MSB - DLY_LSB + 1;
  // status sources
  localparam int N_SRC       = 3;
  localparam int IDX_DONE    = 0;
  localparam int IDX_DLY     = 1;
  localparam int IDX_ERR     = 2;
endpackage

// File: rtl/irqc_ctrl_reg.sv
module irqc_ctrl_reg
  import irqc_pkg::*;
#(
  parameter logic [THR_W-1:0] THR_RST = 1,
  parameter logic [DLY_W-1:0] DLY_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic              run,
  output logic [N_SRC-1:0]  en,
  output logic [THR_W-1:0]  thr,
  output logic [DLY_W-1:0]  dly,
  output logic              thr_wr,
  output logic [THR_W-1:0]  thr_wval,
  output logic [CTRL_W-1:0] rdata
);
  logic             run_q, run_d;
  logic [N_SRC-1:0] en_q, en_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             unused_rsvd;

  assign thr_wval    = wdata[THR_MSB:THR_LSB];
  assign thr_wr      = we && (thr_wval != '0);
  assign unused_rsvd = ^{wdata[11:1], wdata[15]};

  always_comb begin
    run_d = run_q;
    en_d  = en_q;
    thr_d = thr_q;
    dly_d = dly_q;
    if (we) begin
      run_d          = wdata[RUN_BIT];
      en_d[IDX_DONE] = wdata[DONE_EN_BIT];
      en_d[IDX_DLY]  = wdata[DLY_EN_BIT];
      en_d[IDX_ERR]  = wdata[ERR_EN_BIT];
      dly_d          = wdata[DLY_MSB:DLY_LSB];
    end
    if (thr_wr) thr_d = thr_wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      en_q  <= '0;
      thr_q <= THR_RST;
      dly_q <= DLY_RST;
    end else begin
      run_q <= run_d;
      en_q  <= en_d;
      thr_q <= thr_d;
      dly_q <= dly_d;
    end
  end

  always_comb begin
    rdata                  = '0;
    rdata[RUN_BIT]         = run_q;
    rdata[ONE_BIT]         = 1'b1;
    rdata[DONE_EN_BIT]     = en_q[IDX_DONE];
    rdata[DLY_EN_BIT]      = en_q[IDX_DLY];
    rdata[ERR_EN_BIT]      = en_q[IDX_ERR];
    rdata[THR_MSB:THR_LSB] = thr_q;
    rdata[DLY_MSB:DLY_LSB] = dly_q;
  end

  assign run = run_q;
  assign en  = en_q;
  assign thr = thr_q;
  assign dly = dly_q;

  p_thr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q != '0);
  p_zero_thr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && thr_wval == '0) |=> $stable(thr_q));
endmodule

// File: rtl/irqc_countdown.sv
module irqc_countdown #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         evt,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         rearm,
  input  logic [W-1:0] thr,
  output logic         hit
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         take;

  assign take = run && evt && !ld && !rearm;
  assign hit  = take && (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (ld)         cnt_d = ld_val;
    else if (rearm) cnt_d = thr;
    else if (take)  cnt_d = (cnt_q == ONE) ? thr : cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  p_cnt_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  p_hit_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == $past(thr)));
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld && !rearm) |=> $stable(cnt_q));
endmodule

// File: rtl/irqc_delay_tmr.sv
module irqc_delay_tmr #(
  parameter int DW   = 8,
  parameter int TICK = 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] dly,
  input  logic          eop,
  input  logic          sop,
  output logic          fire
);
  localparam int PRE_W = (TICK > 1) ? $clog2(TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK - 1);

  logic             armed_q, armed_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DW-1:0]    ivl_q, ivl_d;
  logic             tick;
  logic [DW:0]      ivl_p1;

  assign tick   = armed_q && (pre_q == PRE_LAST);
  assign ivl_p1 = {1'b0, ivl_q} + (DW+1)'(1);
  assign fire   = run && tick && (dly != '0) && (ivl_p1 >= {1'b0, dly});

  always_comb begin
    armed_d = armed_q;
    pre_d   = pre_q;
    ivl_d   = ivl_q;
    if (!run || dly == '0) begin
      armed_d = 1'b0;
      pre_d   = '0;
      ivl_d   = '0;
    end else if (eop) begin
      armed_d = 1'b1;
      pre_d   = '0;
      ivl_d   = '0;
    end else if (sop || fire) begin
      armed_d = 1'b0;
      pre_d   = '0;
      ivl_d   = '0;
    end else if (armed_q) begin
      if (tick) begin
        pre_d = '0;
        ivl_d = ivl_q + DW'(1);
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pre_q   <= '0;
      ivl_q   <= '0;
    end else begin
      armed_q <= armed_d;
      pre_q   <= pre_d;
      ivl_q   <= ivl_d;
    end
  end

  p_pre_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LAST);
  p_sop_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sop && !eop) |=> !armed_q);
  p_dly_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dly == '0) |=> !armed_q);
  p_halt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !armed_q);
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] sts,
  output logic         irq
);
  logic [N-1:0] sts_q, sts_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb sts_d[i] = set[i] | (sts_q[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= sts_d[i];
    end

    p_set_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> sts_q[i]);
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !sts_q[i]);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !set[i]) |=> $stable(sts_q[i]));
  end

  assign sts = sts_q;
  assign irq = |(sts_q & en);
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import irqc_pkg::*;
#(
  parameter int TICK_CYCLES = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              evt_done,
  input  logic              evt_eop,
  input  logic              evt_sop,
  input  logic              evt_err,
  input  logic              ack_we,
  input  logic [N_SRC-1:0]  ack_data,
  output logic              sts_done,
  output logic              sts_dly,
  output logic              sts_err,
  output logic              irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             run;
  logic [N_SRC-1:0] en;
  logic [THR_W-1:0] thr, thr_wval;
  logic [DLY_W-1:0] dly;
  logic             thr_wr;
  logic             hit, fire;
  logic [N_SRC-1:0] set, clr, sts;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  irqc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .we       (ctrl_we),
    .wdata    (ctrl_wdata),
    .run      (run),
    .en       (en),
    .thr      (thr),
    .dly      (dly),
    .thr_wr   (thr_wr),
    .thr_wval (thr_wval),
    .rdata    (ctrl_rdata)
  );

  irqc_countdown #(.W(THR_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .run    (run),
    .evt    (evt_done),
    .ld     (thr_wr),
    .ld_val (thr_wval),
    .rearm  (fire),
    .thr    (thr),
    .hit    (hit)
  );

  irqc_delay_tmr #(.DW(DLY_W), .TICK(TICK_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run   (run),
    .dly   (dly),
    .eop   (evt_eop),
    .sop   (evt_sop),
    .fire  (fire)
  );

  always_comb begin
    set           = '0;
    set[IDX_DONE] = hit;
    set[IDX_DLY]  = fire;
    set[IDX_ERR]  = evt_err;
    clr           = ack_we ? ack_data : '0;
  end

  irqc_status #(.N(N_SRC)) u_sts (
    .clk   (clk),
    .rst_n (rst_s_n),
    .set   (set),
    .clr   (clr),
    .en    (en),
    .sts   (sts),
    .irq   (irq)
  );

  assign sts_done = sts[IDX_DONE];
  assign sts_dly  = sts[IDX_DLY];
  assign sts_err  = sts[IDX_ERR];

  p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    evt_err |=> sts_err);
  p_halt_no_done_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!run && !sts_done && !(ack_we && ack_data[IDX_DONE])) |=> !sts_done);
endmodule

// File: tb/irq_coalesce_tb.sv
module irq_coalesce_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we;
  logic [31:0] ctrl_wdata;
  logic [31:0] ctrl_rdata;
  logic        evt_done, evt_eop, evt_sop, evt_err;
  logic        ack_we;
  logic [2:0]  ack_data;
  logic        sts_done, sts_dly, sts_err, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  irq_coalesce u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .evt_done   (evt_done),
    .evt_eop    (evt_eop),
    .evt_sop    (evt_sop),
    .evt_err    (evt_err),
    .ack_we     (ack_we),
    .ack_data   (ack_data),
    .sts_done   (sts_done),
    .sts_dly    (sts_dly),
    .sts_err    (sts_err),
    .irq        (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [31:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  // m = {err, sop, eop, done}
  task automatic ev(input logic [3:0] m);
    @(negedge clk);
    {evt_err, evt_sop, evt_eop, evt_done} = m;
    @(negedge clk);
    {evt_err, evt_sop, evt_eop, evt_done} = '0;
  endtask

  task automatic ack(input logic [2:0] m);
    @(negedge clk);
    ack_we = 1'b1; ack_data = m;
    @(negedge clk);
    ack_we = 1'b0; ack_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 readback", ctrl_rdata, 32'h0001_0002);
    chk("R1 status", {sts_err, sts_dly, sts_done}, 3'b000);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_ctrl;
    wr_ctrl(32'hFFFF_FFFF);
    chk("R2 readback all-ones", ctrl_rdata, 32'hFFFF_7003);
    wr_ctrl(32'h0000_0000);
    chk("R3 zero threshold kept", ctrl_rdata, 32'h00FF_0002);
    wr_ctrl(32'h5A00_5000);
    chk("R3 other fields written", ctrl_rdata, 32'h5AFF_5002);
  endtask

  task automatic t_count;
    wr_ctrl(32'h0003_1001);  // run, done_en, thr 3, dly 0
    chk("R2 readback", ctrl_rdata, 32'h0003_1003);
    ev(4'b0001); ev(4'b0001);
    chk("R4 below threshold", sts_done, 1'b0);
    chk("R11 irq idle", irq, 1'b0);
    ev(4'b0001);
    chk("R4 at threshold", sts_done, 1'b1);
    chk("R11 irq on done", irq, 1'b1);
    ack(3'b001);
    chk("R10 ack done", sts_done, 1'b0);
    ev(4'b0001); ev(4'b0001);
    chk("R4 reload partial", sts_done, 1'b0);
    ev(4'b0001);
    chk("R4 reload full", sts_done, 1'b1);
    ack(3'b001);
    ev(4'b0001); ev(4'b0001);
    wr_ctrl(32'h0002_1001);  // new threshold reloads count to 2
    ev(4'b0001);
    chk("R4 write reload partial", sts_done, 1'b0);
    ev(4'b0001);
    chk("R4 write reload full", sts_done, 1'b1);
    ack(3'b001);
  endtask

  task automatic t_delay;
    wr_ctrl(32'h0204_2001);  // run, dly_en, thr 4, dly 2
    ev(4'b0001); ev(4'b0001); ev(4'b0001);
    chk("R4 pending", sts_done, 1'b0);
    ev(4'b0010);
    wait_cyc(249);
    chk("R5 one clock early", sts_dly, 1'b0);
    wait_cyc(1);
    chk("R5 at 250 clocks", sts_dly, 1'b1);
    chk("R11 irq on delay", irq, 1'b1);
    ack(3'b010);
    chk("R10 ack delay", {irq, sts_dly}, 2'b00);
    ev(4'b0001); ev(4'b0001); ev(4'b0001);
    chk("R5 timeout reloaded count", sts_done, 1'b0);
    ev(4'b0001);
    chk("R5 count after reload", sts_done, 1'b1);
    chk("R11 done not enabled", irq, 1'b0);
    ack(3'b001);
  endtask

  task automatic t_sop;
    wr_ctrl(32'h0104_2001);  // dly 1
    ev(4'b0010);
    wait_cyc(100);
    ev(4'b0100);
    wait_cyc(300);
    chk("R6 sop disarms", sts_dly, 1'b0);
    ev(4'b0010);
    wait_cyc(124);
    chk("R5 dly1 early", sts_dly, 1'b0);
    wait_cyc(1);
    chk("R5 dly1 at 125", sts_dly, 1'b1);
    ack(3'b010);
  endtask

  task automatic t_zero_dly;
    wr_ctrl(32'h0004_2001);
    ev(4'b0010);
    wait_cyc(400);
    chk("R7 zero delay", sts_dly, 1'b0);
  endtask

  task automatic t_halt;
    wr_ctrl(32'h0102_3000);  // run 0, done_en, dly_en, thr 2, dly 1
    ev(4'b0001); ev(4'b0001); ev(4'b0001);
    chk("R8 completions ignored", sts_done, 1'b0);
    ev(4'b0010);
    wait_cyc(200);
    chk("R8 timer idle", {irq, sts_dly}, 2'b00);
    ev(4'b1000);
    chk("R9 error while halted", sts_err, 1'b1);
    chk("R11 error not enabled", irq, 1'b0);
    wr_ctrl(32'h0102_7000);
    chk("R11 enable raises irq", irq, 1'b1);
    ack(3'b100);
    chk("R10 ack error", {irq, sts_err}, 2'b00);
    @(negedge clk);
    evt_err = 1'b1; ack_we = 1'b1; ack_data = 3'b100;
    @(negedge clk);
    evt_err = 1'b0; ack_we = 1'b0; ack_data = '0;
    chk("R10 set beats clear", sts_err, 1'b1);
    ack(3'b100);
    chk("R10 cleared after", sts_err, 1'b0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    rst_n = 1'b0;
    ctrl_we = 1'b0; ctrl_wdata = '0;
    {evt_err, evt_sop, evt_eop, evt_done} = '0;
    ack_we = 1'b0; ack_data = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_ctrl();
    t_count();
    t_delay();
    t_sop();
    t_zero_dly();
    t_halt();
    if (!ended) begin
      ended = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule